// File: doc/BRIEF.md
# Instruction Fetch Two-Byte Line Buffer

This block sits between a byte-wide processor port and a memory that is 16 bits wide. It keeps one aligned pair of instruction bytes, the "line", together with the upper address bits of that pair and a valid flag. When an instruction fetch asks for either byte of the held pair, the byte is returned in the same cycle and no memory request is raised. That bus slot is left free for other masters.

A fetch that misses issues one 16-bit read. It returns the selected half of the word in the cycle the memory acknowledges, and it loads the whole word into the line. Data reads and data writes always go to memory and are never served from the line. Each write the processor performs is compared against the held pair. A write to either byte of that pair discards the line, so a later fetch cannot return a stale byte.

Two counters report how many fetches hit and how many missed, so the saving in bus cycles can be measured.

Top module: `fetch_line_buf`

## Requirements
- R1: After reset the line is invalid and both counters read zero. The first instruction fetch after reset is therefore a miss.
- R2: On a missing fetch, the block raises `mem_req` with `mem_we`=0 and `mem_addr` equal to cpu_addr[15:1]. `cpu_ready` stays low until `mem_ack` is high. In the acknowledge cycle `cpu_ready` is 1 and `cpu_rdata` holds the selected byte: mem_rdata[7:0] when cpu_addr[0]=0, or mem_rdata[15:8] when cpu_addr[0]=1.
- R3: A completed miss loads the full word into the line. A later fetch of either byte of that word gets `cpu_ready`=1 in the same cycle, with the correct byte.
- R4: A fetch that hits never raises `mem_req`.
- R5: A data read (`cpu_ifetch`=0, `cpu_we`=0) always goes to memory, even when its word is held in the line. It leaves the line unchanged.
- R6: A write raises `mem_req` and `mem_we`. It drives the data byte onto both halves of `mem_wdata`. It sets `mem_wstrb` to 2'b01 when cpu_addr[0]=0 and to 2'b10 when cpu_addr[0]=1. `cpu_ready` follows `mem_ack`.
- R7: A completed write whose cpu_addr[15:1] equals the held tag invalidates the line, so the next fetch of that word misses and returns the new memory contents. A write to any other word leaves the line valid.
- R8: `hit_count` increases by one for every fetch served from the line. `miss_count` increases by one for every fetch completed by a memory read.
- R9: A fetch to a word other than the held one misses and replaces the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cpu_req | input | 1 | processor access request |
| cpu_we | input | 1 | access is a write |
| cpu_ifetch | input | 1 | access is an instruction fetch |
| cpu_addr | input | 16 | byte address |
| cpu_wdata | input | 8 | write byte |
| cpu_rdata | output | 8 | read byte |
| cpu_ready | output | 1 | access completes this cycle |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | memory write |
| mem_addr | output | 15 | word address |
| mem_wdata | output | 16 | write word, byte replicated |
| mem_wstrb | output | 2 | byte-lane enables |
| mem_rdata | input | 16 | read word |
| mem_ack | input | 1 | memory completes request this cycle |
| hit_count | output | 16 | fetches served from the line |
| miss_count | output | 16 | fetches served by memory |

## Verification
The assertions take three things for granted about the inputs. The processor holds its request and all of its qualifiers steady until the cycle in which `cpu_ready` is high. The memory raises `mem_ack` only while `mem_req` is high. A write plus fetch qualifier is treated as a write. The stimulus keeps to these rules by issuing exactly one access at a time and holding every field until completion. It also raises the acknowledge only after it has seen the request, using a random latency of zero to two cycles. Random addresses are confined to 64 words, so hits, snooped invalidations and data reads of the held word occur often.

// File: rtl/flb_pkg.sv
package flb_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_FETCH = 2'd1,
    ACC_READ  = 2'd2,
    ACC_WRITE = 2'd3
  } acc_kind_t;

  function automatic acc_kind_t classify(input logic req, input logic we, input logic ifetch);
    if (!req)        return ACC_NONE;
    else if (we)     return ACC_WRITE;
    else if (ifetch) return ACC_FETCH;
    else             return ACC_READ;
  endfunction
endpackage

// File: rtl/flb_line.sv
module flb_line #(
  parameter int TAG_W  = 15,
  parameter int BYTE_W = 8,
  localparam int LINE_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_data,
  input  logic              inval_en,
  output logic              hit,
  output logic              valid,
  output logic [TAG_W-1:0]  tag,
  output logic [LINE_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (fill_en) begin
      valid <= 1'b1;
    end else if (inval_en && tag == look_tag) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag  <= look_tag;
      data <= fill_data;
    end
  end

  assign hit = valid && (tag == look_tag);

  assert_fill_excl_inval_R7: assert property (@(posedge clk) disable iff (rst)
    fill_en |-> !inval_en);
endmodule

// File: rtl/flb_stat.sv
module flb_stat #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_evt,
  input  logic             miss_evt,
  output logic [CNT_W-1:0] hits,
  output logic [CNT_W-1:0] misses
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hits   <= '0;
      misses <= '0;
    end else begin
      if (hit_evt)  hits   <= hits + 1'b1;
      if (miss_evt) misses <= misses + 1'b1;
    end
  end

  assert_evt_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(hit_evt && miss_evt));
endmodule

// File: rtl/fetch_line_buf.sv
module fetch_line_buf #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16,
  localparam int TAG_W  = ADDR_W - 1,
  localparam int LINE_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_ifetch,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [TAG_W-1:0]  mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  output logic [1:0]        mem_wstrb,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  import flb_pkg::*;

  acc_kind_t          kind;
  logic [TAG_W-1:0]   word_addr;
  logic               line_hit;
  logic               line_valid;
  logic [TAG_W-1:0]   line_tag;
  logic [LINE_W-1:0]  line_data;
  logic               fetch_hit;
  logic               fill_en;
  logic               inval_en;
  logic [LINE_W-1:0]  src_word;

  assign kind      = classify(cpu_req, cpu_we, cpu_ifetch);
  assign word_addr = cpu_addr[ADDR_W-1:1];

  flb_line #(.TAG_W(TAG_W), .BYTE_W(BYTE_W)) u_line (
    .clk       (clk),
    .rst       (rst),
    .look_tag  (word_addr),
    .fill_en   (fill_en),
    .fill_data (mem_rdata),
    .inval_en  (inval_en),
    .hit       (line_hit),
    .valid     (line_valid),
    .tag       (line_tag),
    .data      (line_data)
  );

  assign fetch_hit = (kind == ACC_FETCH) && line_hit;
  assign fill_en   = (kind == ACC_FETCH) && !line_hit && mem_ack;
  assign inval_en  = (kind == ACC_WRITE) && mem_ack;

  assign mem_req   = (kind != ACC_NONE) && !fetch_hit;
  assign mem_we    = (kind == ACC_WRITE);
  assign mem_addr  = word_addr;
  assign mem_wdata = {2{cpu_wdata}};
  assign mem_wstrb = (kind != ACC_WRITE) ? 2'b11 : (cpu_addr[0] ? 2'b10 : 2'b01);

  assign cpu_ready = fetch_hit || (mem_req && mem_ack);
  assign src_word  = fetch_hit ? line_data : mem_rdata;
  assign cpu_rdata = cpu_addr[0] ? src_word[LINE_W-1:BYTE_W] : src_word[BYTE_W-1:0];

  flb_stat #(.CNT_W(CNT_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .hit_evt  (fetch_hit),
    .miss_evt (fill_en),
    .hits     (hit_count),
    .misses   (miss_count)
  );

  assert_reset_invalid_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !line_valid);

  assert_hit_no_bus_R4: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ifetch && !cpu_we && line_hit) |-> !mem_req);

  assert_busless_only_fetch_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !mem_req) |-> (cpu_ifetch && !cpu_we && cpu_ready));

  assert_miss_fills_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ifetch && !cpu_we && mem_req && mem_ack)
      |=> (line_valid && line_tag == $past(cpu_addr[ADDR_W-1:1])));

  assert_write_snoop_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_we && mem_ack)
      |=> !(line_valid && line_tag == $past(cpu_addr[ADDR_W-1:1])));
endmodule

// File: tb/fetch_line_buf_bench.sv
module fetch_line_buf_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_ifetch = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [1:0]  mem_wstrb;
  logic [15:0] mem_rdata = 16'hDEAD;
  logic        mem_ack = 1'b0;
  logic [15:0] hit_count, miss_count;

  int n_chk = 0, n_fail = 0;
  logic [15:0] bmem [0:63];
  bit          m_valid = 0;
  logic [14:0] m_tag = '0;
  int          m_hits = 0, m_misses = 0;

  always #10 clk = ~clk;

  fetch_line_buf u_fetch_line_buf (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ifetch(cpu_ifetch),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .hit_count(hit_count), .miss_count(miss_count));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pick(input logic [15:0] w, input logic b);
    return b ? w[15:8] : w[7:0];
  endfunction

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic access(input bit we, input bit ifetch, input logic [15:0] addr,
                        input logic [7:0] wd);
    bit exp_hit;
    int lat;
    logic [5:0] wi;
    wi = addr[6:1];
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_ifetch = ifetch; cpu_addr = addr; cpu_wdata = wd;
    mem_ack = 0; mem_rdata = 16'hDEAD;
    #1;
    exp_hit = ifetch && !we && m_valid && (m_tag == addr[15:1]);
    if (exp_hit) begin
      check("R4 hit mem_req", mem_req, 0);
      check("R3 hit ready", cpu_ready, 1);
      check("R3 hit data", cpu_rdata, pick(bmem[wi], addr[0]));
      m_hits++;
    end else begin
      check(ifetch && !we ? "R2 miss mem_req" : "R5 R6 bypass mem_req", mem_req, 1);
      check("R2 mem_addr", mem_addr, addr[15:1]);
      check("R2 R6 mem_we", mem_we, we);
      check("R2 ready low", cpu_ready, 0);
      if (we) begin
        check("R6 wdata", mem_wdata, {wd, wd});
        check("R6 wstrb", mem_wstrb, addr[0] ? 2'b10 : 2'b01);
      end
      lat = $urandom_range(0, 2);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk); #1;
        check("R2 ready waits ack", cpu_ready, 0);
      end
      @(negedge clk);
      mem_ack = 1; mem_rdata = bmem[wi];
      #1;
      check("R2 R6 ready on ack", cpu_ready, 1);
      if (!we) check(ifetch ? "R2 miss data" : "R5 read data", cpu_rdata, pick(bmem[wi], addr[0]));
      if (we) begin
        if (addr[0]) bmem[wi][15:8] = wd; else bmem[wi][7:0] = wd;
        if (m_tag == addr[15:1]) m_valid = 0;
      end else if (ifetch) begin
        m_valid = 1; m_tag = addr[15:1]; m_misses++;
      end
    end
    @(negedge clk);
    cpu_req = 0; cpu_we = 0; cpu_ifetch = 0; mem_ack = 0; mem_rdata = 16'hDEAD;
    #1;
    check("R8 hit_count", hit_count, m_hits);
    check("R8 miss_count", miss_count, m_misses);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) bmem[i] = 16'(i * 16'h1357 + 16'h2468);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    check("R1 hit_count zero", hit_count, 0);
    check("R1 miss_count zero", miss_count, 0);
    check("R1 idle no req", mem_req, 0);
    // R1 R2: first fetch misses
    access(0, 1, 16'h0010, 0);
    // R3: both bytes now hit
    access(0, 1, 16'h0011, 0);
    access(0, 1, 16'h0010, 0);
    // R5: data read of held word still uses memory, line kept
    access(0, 0, 16'h0011, 0);
    access(0, 1, 16'h0011, 0);
    // R7: write elsewhere keeps line, R6 strobes
    access(1, 0, 16'h0041, 8'hA5);
    access(0, 1, 16'h0010, 0);
    // R7: write to held word invalidates, new data fetched
    access(1, 0, 16'h0011, 8'h5C);
    access(0, 1, 16'h0011, 0);
    // R9: different word replaces line
    access(0, 1, 16'h0020, 0);
    access(0, 1, 16'h0010, 0);
    access(1, 1, 16'h0010, 8'h77);
    access(0, 1, 16'h0010, 0);
    for (int k = 0; k < 600; k++) begin
      int sel;
      logic [15:0] a;
      sel = $urandom_range(0, 9);
      a = 16'($urandom_range(0, 127));
      if (sel < 6)      access(0, 1, a, 0);
      else if (sel < 8) access(0, 0, a, 0);
      else              access(1, $urandom_range(0, 1), a, 8'($urandom));
    end
    finish_run();
  end
endmodule